// File: doc/BRIEF.md
# Windowed Adaptive Averaging Filter

This block smooths a stream of signed converter readings shared by four channels. Samples arrive one at a time on a valid/ready input. Each accepted sample belongs to the next channel in a fixed rotation 0, 1, 2, 3, 0, and so on. For that channel the block blends the sample into a stored running average, with a weight set by that channel's filter factor F. If the sample lies outside a per-channel window W around the current average, the average jumps straight to the sample. The filter therefore settles fast after a step in the input and smooths noise while the input is steady.

Each F and W comes from its own plain input field. The four averages are always visible on one packed output bus. A blended update divides by F in a bit-serial divider. While that runs the input is back-pressured: `in_ready` is low, and the sender must hold `in_valid` and `in_sample` until a cycle in which `in_ready` is high. A transfer takes place on a rising edge where both are high. For scale: with a ±10 V full scale on 16 bits, a 0.1 V window is about code 328. A typical factor is 100.

Top module: `wavg_filter`

## Requirements
- R1: After reset all four averages read 0, `in_ready` is 1, `busy` is 0 and the first accepted sample goes to channel 0.
- R2: Accepted samples go to channels in the order 0,1,2,3,0,... Only the addressed channel's average (`avg_bus[16*c +: 16]`, two's complement) can change as a result.
- R3: The first sample accepted for a channel after reset becomes that channel's average. It is visible right after the accepting edge, and `in_ready` stays 1.
- R4: Otherwise, with F ≥ 2 and the sample inside the window, the new average is (avg·(F−1)+sample)/F rounded to nearest with halves away from zero. It appears exactly DW+FW+2 = 26 clock edges after the accepting edge, and `busy` is 1 for those 26 cycles.
- R5: If |sample − avg| is strictly greater than W (`window_bus[16*c +: 16]`, unsigned), the average becomes the sample right after the accepting edge. A difference equal to W is filtered. The difference is formed without overflow over the full 16-bit range.
- R6: A factor (`factor_bus[8*c +: 8]`, unsigned) of 0 or 1 acts as 1: the average becomes the sample right after the accepting edge.
- R7: While `busy` is 1, `in_ready` is 0. A held `in_valid` in that time neither advances the channel rotation nor changes any average.
- R8: In a cycle with no transfer and no pending division, no average changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Sample offered |
| in_ready | output | 1 | Block can take a sample this cycle |
| in_sample | input | 16 | Signed sample for the next channel in rotation |
| factor_bus | input | 32 | Four unsigned 8-bit filter factors, channel c at bits 8c+7:8c |
| window_bus | input | 64 | Four unsigned 16-bit windows, channel c at bits 16c+15:16c |
| avg_bus | output | 64 | Four signed 16-bit averages, channel c at bits 16c+15:16c |
| busy | output | 1 | Division in progress |

## Verification
A bad channel pointer shows at the next transfer: the wrong slice of `avg_bus` moves. A lost first-sample flag shows the same way, because a fresh channel is then blended instead of loaded. A wrong latched sign, channel or divisor stays hidden during the division and surfaces 26 cycles after the transfer as a wrong value on one slice. A stuck state machine shows as `in_ready` never coming back. Because the model compares every slice, `in_ready` and `busy` on every clock, any such fault is flagged on the first cycle it reaches a port.

// File: rtl/wavg_pkg.sv
package wavg_pkg;
  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_DIV  = 1'b1
  } wavg_state_e;
endpackage

// File: rtl/wavg_win_cmp.sv
// Decides whether a sample replaces the average outright and yields the
// effective factor (never below 1).
module wavg_win_cmp #(
  parameter int DW = 16,
  parameter int FW = 8
) (
  input  logic signed [DW-1:0] sample,
  input  logic signed [DW-1:0] avg,
  input  logic        [DW-1:0] window,
  input  logic        [FW-1:0] factor,
  input  logic                 seeded,
  output logic        [FW-1:0] f_eff,
  output logic                 load_direct
);
  logic signed [DW:0] diff;
  logic        [DW:0] mag;
  logic               outside;
  logic               f_small;

  always_comb begin
    diff    = $signed({sample[DW-1], sample}) - $signed({avg[DW-1], avg});
    mag     = diff[DW] ? $unsigned(-diff) : $unsigned(diff);
    outside = mag > {1'b0, window};
    f_small = factor <= FW'(1);
    f_eff   = f_small ? FW'(1) : factor;
    load_direct = !seeded || outside || f_small;
  end
endmodule

// File: rtl/wavg_seq_div.sv
// Restoring bit-serial divider: one quotient bit per clock.
module wavg_seq_div #(
  parameter int DVW = 25,
  parameter int FW  = 8,
  parameter int QW  = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [DVW-1:0] dividend,
  input  logic [FW-1:0]  divisor,
  output logic [QW-1:0]  quotient,
  output logic           done
);
  localparam int CW = $clog2(DVW + 1);

  logic [DVW-1:0] quo_q;
  logic [FW-1:0]  rem_q;
  logic [FW-1:0]  dsr_q;
  logic [CW-1:0]  cnt_q;
  logic [FW:0]    rem_sh;
  logic [FW:0]    rem_sub;
  logic           ge;

  always_comb begin
    rem_sh  = {rem_q, quo_q[DVW-1]};
    ge      = rem_sh >= {1'b0, dsr_q};
    rem_sub = ge ? (rem_sh - {1'b0, dsr_q}) : rem_sh;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      quo_q <= '0;
      rem_q <= '0;
      dsr_q <= '0;
      cnt_q <= '0;
      done  <= 1'b0;
    end else if (start) begin
      quo_q <= dividend;
      rem_q <= '0;
      dsr_q <= divisor;
      cnt_q <= CW'(DVW);
      done  <= 1'b0;
    end else if (cnt_q != '0) begin
      quo_q <= {quo_q[DVW-2:0], ge};
      rem_q <= rem_sub[FW-1:0];
      cnt_q <= cnt_q - 1'b1;
      done  <= (cnt_q == CW'(1));
    end else begin
      done  <= 1'b0;
    end
  end

  assign quotient = quo_q[QW-1:0];
endmodule

// File: rtl/wavg_filter.sv
module wavg_filter
  import wavg_pkg::*;
#(
  parameter int NCH = 4,
  parameter int DW  = 16,
  parameter int FW  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DW-1:0]     in_sample,
  input  logic [NCH*FW-1:0] factor_bus,
  input  logic [NCH*DW-1:0] window_bus,
  output logic [NCH*DW-1:0] avg_bus,
  output logic              busy
);
  localparam int PW  = (NCH > 1) ? $clog2(NCH) : 1;
  localparam int NW  = DW + FW;
  localparam int DVW = NW + 1;

  logic        [FW-1:0] fac_arr [NCH];
  logic        [DW-1:0] win_arr [NCH];
  logic signed [DW-1:0] avg_q   [NCH];
  logic        [NCH-1:0] init_q;

  wavg_state_e   state_q;
  logic [PW-1:0] ptr_q;
  logic [PW-1:0] ptr_nx;
  logic [PW-1:0] pend_q;
  logic          neg_q;

  genvar g;
  generate
    for (g = 0; g < NCH; g++) begin : g_lane
      assign fac_arr[g]             = factor_bus[g*FW +: FW];
      assign win_arr[g]             = window_bus[g*DW +: DW];
      assign avg_bus[g*DW +: DW]    = avg_q[g];
    end
  endgenerate

  assign in_ready = (state_q == ST_IDLE);
  assign busy     = (state_q == ST_DIV);

  logic accept;
  assign accept = in_valid && in_ready;
  assign ptr_nx = (ptr_q == PW'(NCH - 1)) ? '0 : ptr_q + 1'b1;

  // Current-channel decision
  logic signed [DW-1:0] cur_avg;
  logic        [FW-1:0] f_eff;
  logic                 load_direct;
  assign cur_avg = avg_q[ptr_q];

  wavg_win_cmp #(.DW(DW), .FW(FW)) u_win (
    .sample      ($signed(in_sample)),
    .avg         (cur_avg),
    .window      (win_arr[ptr_q]),
    .factor      (fac_arr[ptr_q]),
    .seeded      (init_q[ptr_q]),
    .f_eff       (f_eff),
    .load_direct (load_direct)
  );

  // Weighted numerator, magnitude plus half divisor for rounding
  logic signed [NW:0] avg_x, smp_x, fm1_x, num_s, mag_s;
  logic        [DVW-1:0] dividend;
  always_comb begin
    avg_x    = {{(NW + 1 - DW){cur_avg[DW-1]}}, cur_avg};
    smp_x    = {{(NW + 1 - DW){in_sample[DW-1]}}, in_sample};
    fm1_x    = {{(NW + 1 - FW){1'b0}}, f_eff - 1'b1};
    num_s    = avg_x * fm1_x + smp_x;
    mag_s    = num_s[NW] ? -num_s : num_s;
    dividend = $unsigned(mag_s) + DVW'(f_eff >> 1);
  end

  logic          div_start;
  logic          div_done;
  logic [DW-1:0] div_q;
  assign div_start = accept && !load_direct;

  wavg_seq_div #(.DVW(DVW), .FW(FW), .QW(DW)) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (div_start),
    .dividend (dividend),
    .divisor  (f_eff),
    .quotient (div_q),
    .done     (div_done)
  );

  logic [DW-1:0] result;
  assign result = neg_q ? (~div_q + 1'b1) : div_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ptr_q   <= '0;
      pend_q  <= '0;
      neg_q   <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: if (accept) begin
          ptr_q <= ptr_nx;
          if (!load_direct) begin
            state_q <= ST_DIV;
            pend_q  <= ptr_q;
            neg_q   <= num_s[NW];
          end
        end
        ST_DIV: if (div_done) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < NCH; c++) avg_q[c] <= '0;
      init_q <= '0;
    end else begin
      for (int c = 0; c < NCH; c++) begin
        if (accept && load_direct && (ptr_q == PW'(c))) begin
          avg_q[c]  <= $signed(in_sample);
          init_q[c] <= 1'b1;
        end else if (busy && div_done && (pend_q == PW'(c))) begin
          avg_q[c] <= $signed(result);
        end
      end
    end
  end
endmodule

// File: rtl/wavg_chk.sv
module wavg_chk #(
  parameter int NCH = 4,
  parameter int DW  = 16,
  parameter int FW  = 8,
  parameter int PW  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [DW-1:0]     in_sample,
  input logic [NCH*FW-1:0] factor_bus,
  input logic [NCH*DW-1:0] window_bus,
  input logic [NCH*DW-1:0] avg_bus,
  input logic              busy,
  input logic [PW-1:0]     ch_ptr,
  input logic [NCH-1:0]    ch_init
);
  logic signed [DW-1:0] avg_arr [NCH];
  logic [PW-1:0] ptr_nx;
  logic xfer, far, small_f;
  int   dif;

  always_comb begin
    for (int c = 0; c < NCH; c++) avg_arr[c] = $signed(avg_bus[c*DW +: DW]);
    ptr_nx  = (int'(ch_ptr) == NCH - 1) ? '0 : ch_ptr + 1'b1;
    xfer    = in_valid && in_ready;
    dif     = int'($signed(in_sample)) - int'(avg_arr[ch_ptr]);
    if (dif < 0) dif = -dif;
    far     = dif > int'(window_bus[ch_ptr*DW +: DW]);
    small_f = int'(factor_bus[ch_ptr*FW +: FW]) <= 1;
  end

  a_r2_rotation: assert property (@(posedge clk) disable iff (!rst_n)
    xfer |=> ch_ptr == $past(ptr_nx));

  a_r3_first_load: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && !ch_init[ch_ptr]) |=> avg_arr[$past(ch_ptr)] == $signed($past(in_sample)));

  a_r4_enters_divide: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && ch_init[ch_ptr] && !far && !small_f) |=> busy);

  a_r5_window_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && far) |=> avg_arr[$past(ch_ptr)] == $signed($past(in_sample)));

  a_r6_small_factor: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && small_f) |=> avg_arr[$past(ch_ptr)] == $signed($past(in_sample)));

  a_r7_stall_holds_ptr: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_ready) |=> $stable(ch_ptr));

  a_r8_quiet_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!xfer && !busy) |=> $stable(avg_bus));
endmodule

bind wavg_filter wavg_chk #(.NCH(NCH), .DW(DW), .FW(FW), .PW(PW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .in_sample  (in_sample),
  .factor_bus (factor_bus),
  .window_bus (window_bus),
  .avg_bus    (avg_bus),
  .busy       (busy),
  .ch_ptr     (ptr_q),
  .ch_init    (init_q)
);

// File: tb/wavg_filter_bench.sv
`timescale 1ns/1ps
module wavg_filter_bench;
  localparam int LAT = 16 + 8 + 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [15:0] in_sample = '0;
  logic [31:0] factor_bus = '0;
  logic [63:0] window_bus = '0;
  logic        in_ready, busy;
  logic [63:0] avg_bus;

  int checks = 0, fails = 0, cycles = 0;
  bit done_flag = 0;

  always #4 clk = ~clk;

  wavg_filter u_wavg_filter (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_sample(in_sample), .factor_bus(factor_bus), .window_bus(window_bus),
    .avg_bus(avg_bus), .busy(busy)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int avg_of(input int c);
    return int'($signed(avg_bus[c*16 +: 16]));
  endfunction

  // Behavioural reference model
  int m_avg[4];
  bit m_init[4];
  int m_ptr, m_cnt, m_pend, m_pch;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int c = 0; c < 4; c++) begin m_avg[c] = 0; m_init[c] = 0; end
      m_ptr = 0; m_cnt = 0; m_pend = 0; m_pch = 0;
    end else if (m_cnt > 0) begin
      m_cnt--;
      if (m_cnt == 0) m_avg[m_pch] = m_pend;
    end else if (in_valid) begin
      int s, f, w, d, n, q;
      s = int'($signed(in_sample));
      f = int'(factor_bus[m_ptr*8 +: 8]);
      w = int'(window_bus[m_ptr*16 +: 16]);
      if (f < 1) f = 1;
      d = s - m_avg[m_ptr];
      if (d < 0) d = -d;
      if (!m_init[m_ptr] || d > w || f == 1) begin
        m_avg[m_ptr] = s;
        m_init[m_ptr] = 1;
      end else begin
        n = m_avg[m_ptr] * (f - 1) + s;
        q = ((n < 0 ? -n : n) + f / 2) / f;
        m_pend = (n < 0) ? -q : q;
        m_pch = m_ptr;
        m_cnt = LAT;
      end
      m_ptr = (m_ptr + 1) % 4;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done_flag) begin
      chk(in_ready == (m_cnt == 0), "R7 in_ready vs model", in_ready, m_cnt == 0);
      chk(busy == (m_cnt != 0), "R4 busy vs model", busy, m_cnt != 0);
      for (int c = 0; c < 4; c++)
        chk(avg_of(c) == m_avg[c], "R4 average vs model", avg_of(c), m_avg[c]);
    end
  end

  task automatic set_f(input int c, input int v);
    factor_bus[c*8 +: 8] = 8'(v);
  endtask
  task automatic set_w(input int c, input int v);
    window_bus[c*16 +: 16] = 16'(v);
  endtask

  task automatic send(input int s);
    @(negedge clk);
    in_valid = 1'b1;
    in_sample = 16'(s);
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (busy) begin n++; @(negedge clk); end
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 150000);
      finish_run();
    end
  end

  initial begin
    int n;
    for (int c = 0; c < 4; c++) begin set_f(c, 4); set_w(c, 1000); end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    for (int c = 0; c < 4; c++) chk(avg_of(c) == 0, "R1 reset average", avg_of(c), 0);
    chk(in_ready == 1'b1, "R1 reset in_ready", in_ready, 1);
    chk(busy == 1'b0, "R1 reset busy", busy, 0);

    // R3 first samples, R2 rotation order
    send(100);
    chk(avg_of(0) == 100, "R3 first load ch0", avg_of(0), 100);
    chk(in_ready == 1'b1, "R3 ready after load", in_ready, 1);
    chk(avg_of(1) == 0, "R2 other channel untouched", avg_of(1), 0);
    send(-200); chk(avg_of(1) == -200, "R2 ch1 second in order", avg_of(1), -200);
    send(0);    chk(avg_of(2) == 0, "R2 ch2 third in order", avg_of(2), 0);
    send(32767); chk(avg_of(3) == 32767, "R2 ch3 fourth in order", avg_of(3), 32767);

    // R4 filtered updates with rounding
    send(103);
    wait_idle(n);
    chk(n == LAT, "R4 busy length", n, LAT);
    chk(avg_of(0) == 101, "R4 ch0 rounded", avg_of(0), 101);
    send(-203); wait_idle(n);
    chk(avg_of(1) == -201, "R4 negative rounding", avg_of(1), -201);
    send(2); wait_idle(n);
    chk(avg_of(2) == 1, "R4 half away from zero", avg_of(2), 1);
    send(32000); wait_idle(n);
    chk(avg_of(3) == 32575, "R4 near full scale", avg_of(3), 32575);

    // R5 outside window, R7 stall, R6 small factor
    set_w(0, 10);
    send(112);
    chk(avg_of(0) == 112, "R5 restart outside window", avg_of(0), 112);
    set_f(2, 0);
    send(-205);
    in_valid = 1'b1; in_sample = 16'(500);
    repeat (3) @(negedge clk);
    chk(in_ready == 1'b0, "R7 ready low while busy", in_ready, 0);
    chk(avg_of(2) == 1, "R7 held sample ignored", avg_of(2), 1);
    while (!in_ready) @(negedge clk);
    chk(avg_of(1) == -202, "R4 ch1 after divide", avg_of(1), -202);
    @(negedge clk); in_valid = 1'b0;
    chk(avg_of(2) == 500, "R6 factor 0 loads sample", avg_of(2), 500);
    chk(avg_of(3) == 32575, "R7 ch3 not advanced into", avg_of(3), 32575);
    set_f(3, 2); set_w(3, 65535);
    send(-32768); wait_idle(n);
    chk(avg_of(3) == -97, "R5 wide difference no overflow", avg_of(3), -97);

    // R5 boundary, R6 factor 1, R4 large factor
    send(122); wait_idle(n);
    chk(avg_of(0) == 115, "R5 difference equal to window filters", avg_of(0), 115);
    set_f(1, 1);
    send(-7);
    chk(avg_of(1) == -7, "R6 factor 1 loads sample", avg_of(1), -7);
    set_f(2, 255); set_w(2, 1000);
    send(600); wait_idle(n);
    chk(avg_of(2) == 500, "R4 factor 255", avg_of(2), 500);
    set_w(3, 100);
    send(32767);
    chk(avg_of(3) == 32767, "R5 step restart", avg_of(3), 32767);

    // R8 idle hold
    repeat (5) @(negedge clk);
    chk(avg_of(0) == 115, "R8 idle hold", avg_of(0), 115);

    // Mixed traffic checked against the model every clock
    for (int i = 0; i < 300; i++) begin
      int c, s;
      c = int'($urandom_range(0, 3));
      set_f(c, int'($urandom_range(0, 255)));
      set_w(c, ($urandom_range(0, 3) == 0) ? int'($urandom_range(0, 65535))
                                            : int'($urandom_range(0, 600)));
      if ($urandom_range(0, 4) == 0) s = int'($urandom_range(0, 65535)) - 32768;
      else s = avg_of(i % 4) + int'($urandom_range(0, 400)) - 200;
      if (s > 32767) s = 32767;
      if (s < -32768) s = -32768;
      send(s);
      if ($urandom_range(0, 3) == 0) repeat (int'($urandom_range(1, 4))) @(negedge clk);
    end
    repeat (LAT + 4) @(negedge clk);
    finish_run();
  end
endmodule